// File: doc/BRIEF.md
# Memory Access Checker and Router

This block stands between a load/store unit and the memory system. It takes one request at a time: an access type (instruction fetch, load, store or atomic), an address, a size given as the base-two logarithm of the byte count, write data with an optional metadata tag, and three ordering flags: acquire, release, and reserve (which acts as the conditional flag on the write side). It checks alignment and rejects flag combinations it does not support. It applies a protection verdict that an external checker presents alongside the request. It then sends the access to a device (MMIO) port or a RAM port, depending on which parameterised address window holds the whole access.

Each request completes with a one-cycle response pulse. The pulse carries either an OK status with read data masked to the access width, an architectural exception code, or an "unsupported" status with a code of its own. A request that ends in any error issues nothing downstream. The RAM port also carries a 3-bit ordering kind, so the memory system can apply the right ordering semantics.

Top module: `mac_router`

## Requirements
- R1: After reset `req_ready` is 1, and `rsp_valid`, `mmio_req_valid` and `ram_req_valid` are 0. Once a request has been accepted, `req_ready` stays 0 until the response pulse has been given.
- R2: A fetch or load with acquire or reserve set, whose address is not a multiple of its byte count, returns status EXC (1) with code 4. The same address on a load with no flags is routed normally.
- R3: A store or atomic (type 2 or 3) with release or reserve set, on a misaligned address, returns EXC with code 6. A plain store at that address is routed normally.
- R4: Read-side flag combinations {acq,rel,rsv} map to these `ram_kind` values:
  - 000 → 0
  - 100 → 1
  - 110 → 2
  - 001 → 3
  - 101 → 4
  - 111 → 5
  
  Release without acquire is rejected with status UNSUP (2): code 1 when reserve is clear, code 2 when reserve is set.
- R5: Write-side combinations map to these `ram_kind` values:
  - 000 → 0
  - 010 → 1
  - 001 → 2
  - 011 → 3
  - 110 → 4
  - 111 → 5
  
  Acquire without release is rejected with UNSUP: code 3 when reserve is clear, code 4 when reserve is set.
- R6: With `prot_en` 1 and `prot_fault` 1, the response is EXC with code `prot_code` and no port is driven. With `prot_en` 0, the protection inputs have no effect.
- R7: An access lying wholly inside the MMIO read window (reads) or the MMIO write window (writes) goes to the MMIO port. Otherwise, an access lying wholly inside the RAM window goes to the RAM port. Address, size, write flag and write data are passed on unchanged, and exactly one port strobes for one cycle.
- R8: An access that falls in no window returns EXC with code 1 for a fetch, 5 for a load, and 7 for a store or atomic.
- R9: A RAM write carries `req_meta` when `meta_en` is 1 and the parameter `DEFAULT_META` when it is 0.
- R10: `rsp_valid` pulses for exactly one cycle per request. For an error, the pulse comes in the cycle after acceptance. For a routed access, it comes in the cycle after the selected port's response. OK reads return the port data with bytes above the access width cleared. Writes and errors return 0 data.
- R11: When several errors apply, they are reported in this order: alignment, then unsupported combination, then protection, then window fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept |
| req_type | input | 2 | 0 fetch, 1 load, 2 store, 3 atomic |
| req_addr | input | AW | Byte address |
| req_size | input | 2 | log2 of byte count (0..3) |
| req_acq | input | 1 | Acquire flag |
| req_rel | input | 1 | Release flag |
| req_rsv | input | 1 | Reserve / conditional flag |
| req_wdata | input | DW | Write data |
| req_meta | input | MW | Write metadata |
| meta_en | input | 1 | Use `req_meta` instead of the default |
| prot_en | input | 1 | Protection verdict applies |
| prot_fault | input | 1 | Protection verdict: fault |
| prot_code | input | 5 | Exception code reported on protection fault |
| mmio_req_valid | output | 1 | Device access strobe |
| mmio_write | output | 1 | Device access is a write |
| mmio_addr | output | AW | Device address |
| mmio_size | output | 2 | Device access size |
| mmio_wdata | output | DW | Device write data |
| mmio_resp_valid | input | 1 | Device response |
| mmio_rdata | input | DW | Device read data |
| ram_req_valid | output | 1 | RAM access strobe |
| ram_write | output | 1 | RAM access is a write |
| ram_addr | output | AW | RAM address |
| ram_size | output | 2 | RAM access size |
| ram_kind | output | 3 | Ordering kind |
| ram_wdata | output | DW | RAM write data |
| ram_meta | output | MW | RAM write metadata |
| ram_resp_valid | input | 1 | RAM response |
| ram_rdata | input | DW | RAM read data |
| rsp_valid | output | 1 | Response pulse |
| rsp_status | output | 2 | 0 OK, 1 EXC, 2 UNSUP |
| rsp_code | output | 5 | Exception or unsupported code |
| rsp_rdata | output | DW | Masked read data |

## Verification
The hardest case to reach is an access that straddles a window edge. It starts inside a window but its last byte falls outside, or it sits in the part of the device range that is readable but not writable. Uniform random addresses almost never land there.

The stimulus therefore draws addresses near window bases and limits, with every size and with deliberate misalignment. Directed cases pin the read-only device area and the RAM end boundary. Combined faults, such as a misaligned unsupported access with a protection fault present, are forced directly to exercise the priority order.

// File: rtl/mac_pkg.sv
// Shared types and code values for the memory access checker and router.
// Assumes exception codes fit in 5 bits.
package mac_pkg;

    typedef enum logic [1:0] {
        ST_OK    = 2'd0,
        ST_EXC   = 2'd1,
        ST_UNSUP = 2'd2
    } rsp_status_e;

    typedef enum logic [1:0] {
        RT_NONE = 2'd0,
        RT_MMIO = 2'd1,
        RT_RAM  = 2'd2
    } route_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_WAIT  = 2'd2,
        S_RESP  = 2'd3
    } fsm_e;

    localparam logic [4:0] EXC_FETCH_FAULT = 5'd1;
    localparam logic [4:0] EXC_LOAD_MISAL  = 5'd4;
    localparam logic [4:0] EXC_LOAD_FAULT  = 5'd5;
    localparam logic [4:0] EXC_STORE_MISAL = 5'd6;
    localparam logic [4:0] EXC_STORE_FAULT = 5'd7;

    localparam logic [4:0] UNS_LOAD_REL    = 5'd1;
    localparam logic [4:0] UNS_RSVLOAD_REL = 5'd2;
    localparam logic [4:0] UNS_STORE_ACQ   = 5'd3;
    localparam logic [4:0] UNS_CONDST_ACQ  = 5'd4;

endpackage

// File: rtl/mac_order_decode.sv
// Ordering-flag decoder.
// Classifies an access's acquire/release/reserve flags into an ordering
// kind, flags unsupported combinations, and checks alignment for ordered or
// reserved accesses only. Purely combinational; it sees only the low
// address bits that matter for alignment.
module mac_order_decode
    import mac_pkg::*;
#(
    parameter int unsigned LOWB = 3,
    parameter int unsigned SZW  = 2
) (
    input  logic            is_write,
    input  logic [SZW-1:0]  size,
    input  logic [LOWB-1:0] addr_low,
    input  logic            acq,
    input  logic            rel,
    input  logic            rsv,
    output logic            misal,
    output logic            unsup,
    output logic [4:0]      unsup_code,
    output logic [2:0]      kind
);

    logic [LOWB-1:0] low_mask;
    logic            off_grid;
    logic            needs_align;

    // Mask of address bits that must be zero for the given size.
    always_comb begin
        low_mask = LOWB'((32'd1 << size) - 32'd1);
        off_grid = |(addr_low & low_mask);
    end

    // Which flags demand natural alignment depends on the direction.
    always_comb begin
        needs_align = is_write ? (rel | rsv) : (acq | rsv);
        misal       = needs_align & off_grid;
    end

    // Flag combination to ordering kind, or to an unsupported code.
    always_comb begin
        unsup      = 1'b0;
        unsup_code = 5'd0;
        kind       = 3'd0;
        if (!is_write) begin
            case ({acq, rel, rsv})
                3'b000: kind = 3'd0;
                3'b100: kind = 3'd1;
                3'b110: kind = 3'd2;
                3'b001: kind = 3'd3;
                3'b101: kind = 3'd4;
                3'b111: kind = 3'd5;
                3'b010: begin unsup = 1'b1; unsup_code = UNS_LOAD_REL;    end
                default: begin unsup = 1'b1; unsup_code = UNS_RSVLOAD_REL; end
            endcase
        end else begin
            case ({acq, rel, rsv})
                3'b000: kind = 3'd0;
                3'b010: kind = 3'd1;
                3'b001: kind = 3'd2;
                3'b011: kind = 3'd3;
                3'b110: kind = 3'd4;
                3'b111: kind = 3'd5;
                3'b100: begin unsup = 1'b1; unsup_code = UNS_STORE_ACQ;  end
                default: begin unsup = 1'b1; unsup_code = UNS_CONDST_ACQ; end
            endcase
        end
    end

endmodule

// File: rtl/mac_window_match.sv
// Address window matcher.
// Reports whether every byte of an access lies in [BASE, BASE+SPAN).
// The arithmetic is one bit wider than the address so the end of the
// access cannot wrap. Assumes BASE+SPAN does not exceed 2**AW.
module mac_window_match #(
    parameter int unsigned    AW   = 32,
    parameter int unsigned    SZW  = 2,
    parameter logic [AW-1:0]  BASE = '0,
    parameter logic [AW-1:0]  SPAN = '0
) (
    input  logic [AW-1:0]  addr,
    input  logic [SZW-1:0] size,
    output logic           hit
);

    localparam logic [AW:0] LIMIT = {1'b0, BASE} + {1'b0, SPAN};

    logic [AW:0] last_excl;

    // End of the access (exclusive), then both bounds compared.
    always_comb begin
        last_excl = {1'b0, addr} + ((AW+1)'(1) << size);
        hit       = ({1'b0, addr} >= {1'b0, BASE}) && (last_excl <= LIMIT);
    end

endmodule

// File: rtl/mac_router.sv
// Memory access checker and router (top).
// Accepts one request at a time over valid/ready. A request is decoded on
// acceptance: alignment, flag legality, protection verdict, then the window
// lookup. Errors answer in the next cycle. Routed accesses strobe one port
// for one cycle and wait for that port's response. Assumes each port
// answers once per strobe, no earlier than the cycle after the strobe.
module mac_router
    import mac_pkg::*;
#(
    parameter int unsigned   AW           = 32,
    parameter int unsigned   DW           = 64,
    parameter int unsigned   MW           = 4,
    parameter logic [MW-1:0] DEFAULT_META = 4'h0,
    parameter logic [AW-1:0] RAM_BASE     = 32'h8000_0000,
    parameter logic [AW-1:0] RAM_SPAN     = 32'h1000_0000,
    parameter logic [AW-1:0] MRD_BASE     = 32'h0200_0000,
    parameter logic [AW-1:0] MRD_SPAN     = 32'h0001_0000,
    parameter logic [AW-1:0] MWR_BASE     = 32'h0200_0000,
    parameter logic [AW-1:0] MWR_SPAN     = 32'h0000_8000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_type,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_size,
    input  logic          req_acq,
    input  logic          req_rel,
    input  logic          req_rsv,
    input  logic [DW-1:0] req_wdata,
    input  logic [MW-1:0] req_meta,
    input  logic          meta_en,
    input  logic          prot_en,
    input  logic          prot_fault,
    input  logic [4:0]    prot_code,
    output logic          mmio_req_valid,
    output logic          mmio_write,
    output logic [AW-1:0] mmio_addr,
    output logic [1:0]    mmio_size,
    output logic [DW-1:0] mmio_wdata,
    input  logic          mmio_resp_valid,
    input  logic [DW-1:0] mmio_rdata,
    output logic          ram_req_valid,
    output logic          ram_write,
    output logic [AW-1:0] ram_addr,
    output logic [1:0]    ram_size,
    output logic [2:0]    ram_kind,
    output logic [DW-1:0] ram_wdata,
    output logic [MW-1:0] ram_meta,
    input  logic          ram_resp_valid,
    input  logic [DW-1:0] ram_rdata,
    output logic          rsp_valid,
    output logic [1:0]    rsp_status,
    output logic [4:0]    rsp_code,
    output logic [DW-1:0] rsp_rdata
);

    localparam int unsigned NBYTES = DW / 8;
    localparam int unsigned LOWB   = $clog2(NBYTES);
    localparam int unsigned SZW    = 2;
    localparam int unsigned NWIN   = 3;
    localparam int unsigned W_MRD  = 0;
    localparam int unsigned W_MWR  = 1;
    localparam int unsigned W_RAM  = 2;

    fsm_e            state_q;
    logic            wr_q;
    logic [AW-1:0]   addr_q;
    logic [1:0]      size_q;
    logic [DW-1:0]   wdata_q;
    logic [MW-1:0]   meta_q;
    logic [2:0]      kind_q;
    route_e          route_q;
    rsp_status_e     status_q;
    logic [4:0]      code_q;
    logic [DW-1:0]   rdata_q;

    logic            accept;
    logic            is_write;
    logic            dec_misal;
    logic            dec_unsup;
    logic [4:0]      dec_unsup_code;
    logic [2:0]      dec_kind;
    logic [NWIN-1:0] win_hit;
    rsp_status_e     nxt_status;
    logic [4:0]      nxt_code;
    route_e          nxt_route;
    logic            port_resp;
    logic [DW-1:0]   port_data;

    // Handshake and direction of the offered request.
    always_comb begin
        req_ready = (state_q == S_IDLE);
        accept    = req_valid && req_ready;
        is_write  = req_type[1];
    end

    mac_order_decode #(
        .LOWB (LOWB),
        .SZW  (SZW)
    ) u_order (
        .is_write   (is_write),
        .size       (req_size),
        .addr_low   (req_addr[LOWB-1:0]),
        .acq        (req_acq),
        .rel        (req_rel),
        .rsv        (req_rsv),
        .misal      (dec_misal),
        .unsup      (dec_unsup),
        .unsup_code (dec_unsup_code),
        .kind       (dec_kind)
    );

    // One matcher per address window, bounds chosen by index.
    for (genvar w = 0; w < NWIN; w++) begin : g_win
        localparam logic [AW-1:0] WB = (w == W_MRD) ? MRD_BASE :
                                       (w == W_MWR) ? MWR_BASE : RAM_BASE;
        localparam logic [AW-1:0] WS = (w == W_MRD) ? MRD_SPAN :
                                       (w == W_MWR) ? MWR_SPAN : RAM_SPAN;
        mac_window_match #(
            .AW   (AW),
            .SZW  (SZW),
            .BASE (WB),
            .SPAN (WS)
        ) u_win (
            .addr (req_addr),
            .size (req_size),
            .hit  (win_hit[w])
        );
    end

    // Outcome of the offered request in fixed fault priority.
    always_comb begin
        nxt_status = ST_OK;
        nxt_code   = 5'd0;
        nxt_route  = RT_NONE;
        if (dec_misal) begin
            nxt_status = ST_EXC;
            nxt_code   = is_write ? EXC_STORE_MISAL : EXC_LOAD_MISAL;
        end else if (dec_unsup) begin
            nxt_status = ST_UNSUP;
            nxt_code   = dec_unsup_code;
        end else if (prot_en && prot_fault) begin
            nxt_status = ST_EXC;
            nxt_code   = prot_code;
        end else if (is_write ? win_hit[W_MWR] : win_hit[W_MRD]) begin
            nxt_route  = RT_MMIO;
        end else if (win_hit[W_RAM]) begin
            nxt_route  = RT_RAM;
        end else begin
            nxt_status = ST_EXC;
            case (req_type)
                2'd0:    nxt_code = EXC_FETCH_FAULT;
                2'd1:    nxt_code = EXC_LOAD_FAULT;
                default: nxt_code = EXC_STORE_FAULT;
            endcase
        end
    end

    // Response from whichever port the held request went to.
    always_comb begin
        port_resp = (route_q == RT_MMIO) ? mmio_resp_valid :
                    (route_q == RT_RAM)  ? ram_resp_valid  : 1'b0;
        port_data = (route_q == RT_MMIO) ? mmio_rdata : ram_rdata;
    end

    // Keep only the bytes that belong to an access of the given size.
    function automatic logic [DW-1:0] trim(input logic [DW-1:0] d,
                                           input logic [1:0]    s);
        logic [DW-1:0] m;
        m = '0;
        for (int b = 0; b < int'(NBYTES); b++) begin
            if (b < (1 << s)) m[b*8 +: 8] = 8'hFF;
        end
        return d & m;
    endfunction

    // Request sequencer: idle, strobe, wait for the port, answer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            wr_q     <= 1'b0;
            addr_q   <= '0;
            size_q   <= '0;
            wdata_q  <= '0;
            meta_q   <= '0;
            kind_q   <= '0;
            route_q  <= RT_NONE;
            status_q <= ST_OK;
            code_q   <= '0;
            rdata_q  <= '0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (accept) begin
                        wr_q     <= is_write;
                        addr_q   <= req_addr;
                        size_q   <= req_size;
                        wdata_q  <= req_wdata;
                        meta_q   <= meta_en ? req_meta : DEFAULT_META;
                        kind_q   <= dec_kind;
                        route_q  <= nxt_route;
                        status_q <= nxt_status;
                        code_q   <= nxt_code;
                        rdata_q  <= '0;
                        state_q  <= (nxt_route == RT_NONE) ? S_RESP : S_ISSUE;
                    end
                end
                S_ISSUE: state_q <= S_WAIT;
                S_WAIT: begin
                    if (port_resp) begin
                        rdata_q <= wr_q ? '0 : trim(port_data, size_q);
                        state_q <= S_RESP;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Port strobes and the held request fields.
    always_comb begin
        mmio_req_valid = (state_q == S_ISSUE) && (route_q == RT_MMIO);
        ram_req_valid  = (state_q == S_ISSUE) && (route_q == RT_RAM);
        mmio_write     = wr_q;
        mmio_addr      = addr_q;
        mmio_size      = size_q;
        mmio_wdata     = wdata_q;
        ram_write      = wr_q;
        ram_addr       = addr_q;
        ram_size       = size_q;
        ram_kind       = kind_q;
        ram_wdata      = wdata_q;
        ram_meta       = meta_q;
    end

    // Response outputs.
    always_comb begin
        rsp_valid  = (state_q == S_RESP);
        rsp_status = status_q;
        rsp_code   = code_q;
        rsp_rdata  = rdata_q;
    end

    AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        !(mmio_req_valid && ram_req_valid)); // R7
    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (mmio_req_valid || ram_req_valid) |=> !(mmio_req_valid || ram_req_valid)); // R7
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R10
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready); // R1
    AST_ALIGN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec_misal) |=> (rsp_valid && rsp_status == ST_EXC)); // R11
    AST_UNSUP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dec_unsup && !dec_misal) |=>
        (rsp_valid && rsp_status == ST_UNSUP && !mmio_req_valid && !ram_req_valid)); // R4
    AST_PROT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && prot_en && prot_fault) |=> (!mmio_req_valid && !ram_req_valid)); // R6
    AST_RAM_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        ram_req_valid |-> (ram_addr >= RAM_BASE)); // R7

endmodule

// File: tb/mac_router_bench.sv
module mac_router_bench;

    localparam int unsigned AW = 32;
    localparam int unsigned DW = 64;
    localparam int unsigned MW = 4;
    localparam logic [MW-1:0] DMETA = 4'h9;
    localparam logic [AW-1:0] RAMB = 32'h8000_0000, RAMS = 32'h1000_0000;
    localparam logic [AW-1:0] MRB  = 32'h0200_0000, MRS  = 32'h0001_0000;
    localparam logic [AW-1:0] MWB  = 32'h0200_0000, MWS  = 32'h0000_8000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [1:0] req_type = '0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0] req_size = '0;
    logic req_acq = 1'b0, req_rel = 1'b0, req_rsv = 1'b0;
    logic [DW-1:0] req_wdata = '0;
    logic [MW-1:0] req_meta = '0;
    logic meta_en = 1'b0, prot_en = 1'b0, prot_fault = 1'b0;
    logic [4:0] prot_code = '0;
    logic mmio_req_valid, mmio_write;
    logic [AW-1:0] mmio_addr;
    logic [1:0] mmio_size;
    logic [DW-1:0] mmio_wdata;
    logic mmio_resp_valid = 1'b0;
    logic [DW-1:0] mmio_rdata = '0;
    logic ram_req_valid, ram_write;
    logic [AW-1:0] ram_addr;
    logic [1:0] ram_size;
    logic [2:0] ram_kind;
    logic [DW-1:0] ram_wdata;
    logic [MW-1:0] ram_meta;
    logic ram_resp_valid = 1'b0;
    logic [DW-1:0] ram_rdata = '0;
    logic rsp_valid;
    logic [1:0] rsp_status;
    logic [4:0] rsp_code;
    logic [DW-1:0] rsp_rdata;

    int checks = 0;
    int fails = 0;
    int issues = 0;
    int seen_port = 0;
    logic [AW-1:0] seen_addr;
    logic [2:0] seen_kind;
    logic [MW-1:0] seen_meta;
    logic [DW-1:0] seen_wdata;
    logic seen_write;

    always #5 clk = ~clk;

    mac_router #(
        .AW(AW), .DW(DW), .MW(MW), .DEFAULT_META(DMETA),
        .RAM_BASE(RAMB), .RAM_SPAN(RAMS), .MRD_BASE(MRB), .MRD_SPAN(MRS),
        .MWR_BASE(MWB), .MWR_SPAN(MWS)
    ) u_mac_router (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_type(req_type), .req_addr(req_addr), .req_size(req_size),
        .req_acq(req_acq), .req_rel(req_rel), .req_rsv(req_rsv),
        .req_wdata(req_wdata), .req_meta(req_meta), .meta_en(meta_en),
        .prot_en(prot_en), .prot_fault(prot_fault), .prot_code(prot_code),
        .mmio_req_valid(mmio_req_valid), .mmio_write(mmio_write),
        .mmio_addr(mmio_addr), .mmio_size(mmio_size), .mmio_wdata(mmio_wdata),
        .mmio_resp_valid(mmio_resp_valid), .mmio_rdata(mmio_rdata),
        .ram_req_valid(ram_req_valid), .ram_write(ram_write), .ram_addr(ram_addr),
        .ram_size(ram_size), .ram_kind(ram_kind), .ram_wdata(ram_wdata),
        .ram_meta(ram_meta), .ram_resp_valid(ram_resp_valid), .ram_rdata(ram_rdata),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_code(rsp_code),
        .rsp_rdata(rsp_rdata)
    );

    function automatic logic [DW-1:0] ram_model(input logic [AW-1:0] a);
        return {~a, a};
    endfunction

    function automatic logic [DW-1:0] dev_model(input logic [AW-1:0] a);
        return {a ^ 32'hC0DE_0000, a ^ 32'h5A5A_5A5A};
    endfunction

    function automatic logic [DW-1:0] keep_bytes(input logic [DW-1:0] d, input int s);
        if (s == 3) return d;
        return d & ((64'd1 << (8 << s)) - 64'd1);
    endfunction

    function automatic bit inside_win(input logic [AW-1:0] a, input int s,
                                      input logic [AW-1:0] b, input logic [AW-1:0] sp);
        longint unsigned lo = longint'(a);
        longint unsigned hi = lo + (longint'(1) << s);
        return (lo >= longint'(b)) && (hi <= longint'(b) + longint'(sp));
    endfunction

    // Port models: record the strobe, answer 1..3 cycles later.
    initial begin
        forever begin
            @(negedge clk);
            if (mmio_req_valid || ram_req_valid) begin
                seen_port  = mmio_req_valid ? 1 : 2;
                seen_addr  = mmio_req_valid ? mmio_addr : ram_addr;
                seen_write = mmio_req_valid ? mmio_write : ram_write;
                seen_wdata = mmio_req_valid ? mmio_wdata : ram_wdata;
                seen_kind  = ram_kind;
                seen_meta  = ram_meta;
                issues++;
                repeat (1 + ($urandom % 3)) @(negedge clk);
                if (seen_port == 1) begin
                    mmio_rdata = dev_model(seen_addr); mmio_resp_valid = 1'b1;
                end else begin
                    ram_rdata = ram_model(seen_addr); ram_resp_valid = 1'b1;
                end
                @(negedge clk);
                mmio_resp_valid = 1'b0;
                ram_resp_valid  = 1'b0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint unsigned act, input longint unsigned exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    // One request end to end, with expectations derived from R2..R11.
    task automatic run_req(input int typ, input logic [AW-1:0] addr, input int sz,
                           input bit a, input bit r, input bit v,
                           input bit pen, input bit pf, input logic [4:0] pc,
                           input bit men, input logic [MW-1:0] mt,
                           input logic [DW-1:0] wd, input string tag);
        bit wr = (typ >= 2);
        bit off = (addr & ((32'd1 << sz) - 1)) != 0;
        int est = 0;
        int ecode = 0;
        int eroute = 0;
        int ekind = 0;
        int iss0;
        int waitc;
        logic [DW-1:0] edata = '0;
        // R4 / R5 kind table and unsupported codes
        if (!wr) begin
            case ({a, r, v})
                3'b000: ekind = 0; 3'b100: ekind = 1; 3'b110: ekind = 2;
                3'b001: ekind = 3; 3'b101: ekind = 4; 3'b111: ekind = 5;
                default: ekind = -1;
            endcase
        end else begin
            case ({a, r, v})
                3'b000: ekind = 0; 3'b010: ekind = 1; 3'b001: ekind = 2;
                3'b011: ekind = 3; 3'b110: ekind = 4; 3'b111: ekind = 5;
                default: ekind = -1;
            endcase
        end
        if (off && (wr ? (r || v) : (a || v))) begin
            est = 1; ecode = wr ? 6 : 4;                  // R2 R3 R11
        end else if (ekind < 0) begin
            est = 2;
            ecode = wr ? (v ? 4 : 3) : (v ? 2 : 1);       // R4 R5
        end else if (pen && pf) begin
            est = 1; ecode = int'(pc);                    // R6
        end else if (wr ? inside_win(addr, sz, MWB, MWS) : inside_win(addr, sz, MRB, MRS)) begin
            eroute = 1;                                   // R7
            if (!wr) edata = keep_bytes(dev_model(addr), sz);
        end else if (inside_win(addr, sz, RAMB, RAMS)) begin
            eroute = 2;
            if (!wr) edata = keep_bytes(ram_model(addr), sz);
        end else begin
            est = 1; ecode = (typ == 0) ? 1 : (typ == 1) ? 5 : 7; // R8
        end

        @(negedge clk);
        check(req_ready == 1'b1, "R1", {tag, " ready when idle"}, req_ready, 1);
        req_type = 2'(typ); req_addr = addr; req_size = 2'(sz);
        req_acq = a; req_rel = r; req_rsv = v;
        prot_en = pen; prot_fault = pf; prot_code = pc;
        meta_en = men; req_meta = mt; req_wdata = wd;
        req_valid = 1'b1;
        iss0 = issues;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R1", {tag, " busy after accept"}, req_ready, 0);
        waitc = 0;
        while (!rsp_valid && waitc < 60) begin
            @(negedge clk);
            waitc++;
        end
        check(rsp_valid == 1'b1, "R10", {tag, " response arrives"}, rsp_valid, 1);
        check(rsp_status == 2'(est), "R11", {tag, " status"}, rsp_status, est);
        if (est != 0)
            check(rsp_code == 5'(ecode), "R8", {tag, " code"}, rsp_code, ecode);
        check(rsp_rdata == edata, "R10", {tag, " data"}, rsp_rdata, edata);
        check((issues - iss0) == (eroute != 0 ? 1 : 0), "R6",
              {tag, " downstream strobes"}, issues - iss0, eroute != 0);
        if (eroute != 0) begin
            check(seen_port == eroute, "R7", {tag, " port"}, seen_port, eroute);
            check(seen_addr == addr, "R7", {tag, " address"}, seen_addr, addr);
            check(seen_write == wr, "R7", {tag, " direction"}, seen_write, wr);
            if (wr) check(seen_wdata == wd, "R7", {tag, " wdata"}, seen_wdata, wd);
        end
        if (eroute == 2) begin
            check(int'(seen_kind) == ekind, wr ? "R5" : "R4", {tag, " kind"}, seen_kind, ekind);
            if (wr) check(seen_meta == (men ? mt : DMETA), "R9", {tag, " meta"},
                          seen_meta, men ? mt : DMETA);
        end
        @(negedge clk);
        check(rsp_valid == 1'b0, "R10", {tag, " single pulse"}, rsp_valid, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1 && !rsp_valid && !mmio_req_valid && !ram_req_valid,
              "R1", "reset state", {req_ready, rsp_valid, mmio_req_valid, ram_req_valid}, 4'b1000);

        // R2 alignment only for ordered or reserved loads
        run_req(1, RAMB + 32'h3, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 plain misaligned load");
        run_req(1, RAMB + 32'h2, 2, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R2 acquire misaligned");
        run_req(0, RAMB + 32'h1, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R2 reserved fetch misaligned");
        // R3 store side
        run_req(2, RAMB + 32'h4, 3, 0, 1, 0, 0, 0, 0, 0, 0, 64'h11, "R3 release misaligned");
        run_req(2, RAMB + 32'h5, 3, 0, 0, 0, 0, 0, 0, 0, 0, 64'h22, "R3 plain misaligned store");
        // R4 R5 every flag combination on both sides
        for (int f = 0; f < 8; f++) begin
            run_req(1, RAMB + 32'h40, 3, f[2], f[1], f[0], 0, 0, 0, 0, 0, 0, "R4 load flags");
            run_req(2, RAMB + 32'h80, 3, f[2], f[1], f[0], 0, 0, 0, 1, 4'(f), 64'(f), "R5 store flags");
        end
        // R6 protection
        run_req(1, RAMB + 32'h100, 2, 0, 0, 0, 1, 1, 5'd5, 0, 0, 0, "R6 protection fault");
        run_req(1, RAMB + 32'h100, 2, 0, 0, 0, 0, 1, 5'd5, 0, 0, 0, "R6 protection disabled");
        // R7 R8 windows
        run_req(1, MRB + 32'hC000, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7 read-only device read");
        run_req(2, MRB + 32'hC000, 2, 0, 0, 0, 0, 0, 0, 0, 0, 64'h5, "R8 read-only device write");
        run_req(2, MWB + 32'h7FF8, 3, 0, 0, 0, 0, 0, 0, 0, 0, 64'h7, "R7 device write at edge");
        run_req(0, 32'h0000_1000, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 fetch unmapped");
        run_req(1, 32'h0000_1000, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 load unmapped");
        run_req(3, 32'h0000_1000, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 atomic unmapped");
        run_req(1, RAMB + RAMS - 32'h4, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 straddles RAM end");
        // R9 metadata
        run_req(2, RAMB + 32'h200, 2, 0, 0, 0, 0, 0, 0, 0, 4'h3, 64'hAB, "R9 default meta");
        run_req(2, RAMB + 32'h200, 2, 0, 0, 0, 0, 0, 0, 1, 4'h3, 64'hAB, "R9 given meta");
        // R11 priority
        run_req(1, RAMB + 32'h1, 2, 0, 1, 1, 1, 1, 5'd5, 0, 0, 0, "R11 misal over unsupported");
        run_req(2, RAMB + 32'h0, 2, 1, 0, 0, 1, 1, 5'd7, 0, 0, 0, "R11 unsupported over protection");

        // Random mix weighted toward window edges
        for (int n = 0; n < 400; n++) begin
            int sel = $urandom % 6;
            int sz = $urandom % 4;
            logic [AW-1:0] ad;
            case (sel)
                0: ad = RAMB + ($urandom % 32'h1000);
                1: ad = RAMB + RAMS - ($urandom % 16);
                2: ad = MRB + ($urandom % MRS);
                3: ad = MWB + MWS - ($urandom % 16);
                4: ad = MRB + MRS - ($urandom % 16);
                default: ad = $urandom;
            endcase
            if ($urandom % 2) ad = ad & ~((32'd1 << sz) - 1);
            run_req($urandom % 4, ad, sz, 1'($urandom), 1'($urandom), 1'($urandom),
                    1'($urandom), ($urandom % 4) == 0, 5'($urandom % 8),
                    1'($urandom), 4'($urandom), {$urandom, $urandom}, "R7 random");
        end
        finish_run();
    end

endmodule